// File: doc/BRIEF.md
# I2C-over-AUX EDID Responder

This block stands in for the sink side of an I2C-over-AUX channel, so that a display driver can read a monitor's EDID without a physical link. Software writes a request word into the first data register. It then writes the control register with the send bit set and a message size. In the cycle the control write is accepted, the block decodes the request and updates its I2C session. It then rewrites control with a done status and a reply size, and replaces the request word with an ACK reply. A single-byte read reply also carries the next EDID byte.

The session has three parts: a target-selected flag, an EDID-available flag and a byte pointer. Address-only messages (size 3) open the session, close it or reset it. EDID content sits in a local 128-byte store, which is filled through a separate load port.

Register writes enter through a valid/ready port. The port never applies back-pressure: `wr_ready` stays high out of reset, and a write is taken on every rising edge where `wr_valid` is high. Its effect can be read on the combinational read port from the next cycle on. The load port and the monitor-present input are plain, with no handshake.

Top module: `aux_edid_responder`

## Requirements
- R1: The five data registers sit at offsets 0x14, 0x18, 0x1C, 0x20 and 0x24. A write to any of them stores the full 32-bit word. An offset other than 0x10 or a data offset reads as 0, and writes to it change nothing.
- R2: A write to control (offset 0x10) with bit 31 clear sets control to 0. It leaves the data registers and the session unchanged.
- R3: A write to control with bit 31 set makes control read done (bit 30) with the reply size in bits 24:20. The reply size is 2 when the command nibble (data register 1 bits 31:28) has bit 0 set (read), and 1 otherwise. The message size is taken from the written bits 24:20.
- R4: A size-3 request with command bit 2 (middle-of-transaction) clear closes the session. After it, reads return 0xFF. The pointer restarts at 0 once the session is reopened.
- R5: A size-3 request with command bit 2 set and address 0x0050 (data register 1 bits 23:8) selects the EDID target. When `dp_mon_present` is 1, it also marks EDID as available.
- R6: A size-3 request with command bit 2 set and address 0 resets the session, in the same way as R4.
- R7: A target selected while `dp_mon_present` is 0 has no EDID available, so reads return 0xFF.
- R8: A read request (command bit 0 set) with size 4, on a selected and available session, returns the byte at the pointer in data register 1 bits 23:16. Bits 31:24 (ACK = 0x00) and bits 15:0 are 0. The pointer then advances by one.
- R9: A size-4 read without a selected and available session returns 0x00FF0000 and does not move the pointer.
- R10: A write request (command bit 0 clear) of any size other than 3 leaves data register 1 at 0x00000000 (ACK only) and leaves the session unchanged. A size-3 request also writes back 0x00000000.
- R11: A read request whose size is neither 3 nor 4 leaves data register 1 unchanged, while control still reports done.
- R12: The pointer saturates at 128. Reads at or past the end return 0x00.
- R13: After reset every register reads 0 and `wr_ready` is 1.
- R14: The load port writes `edid_ld_byte` into store entry `edid_ld_idx`, and that entry is what a later read at that pointer returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Register write accepted (always 1 out of reset) |
| wr_addr | input | 8 | Register byte offset of the write |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register byte offset to read |
| rd_data | output | 32 | Combinational register read data |
| edid_ld_en | input | 1 | Load one byte into the EDID store |
| edid_ld_idx | input | 7 | Store entry to load |
| edid_ld_byte | input | 8 | Byte to load |
| dp_mon_present | input | 1 | A DP monitor is attached, so EDID may be offered |

## Verification
Reads are tried in several session states:
- Reads on a fresh session, after a close, after an address-0 reset and after a select with no monitor all expect the 0xFF filler. This separates them from real EDID bytes.
- A long run of consecutive reads walks the pointer across the top of the store. It shows that the last valid entry is still delivered and that everything past it reads 0x00.
- A write request and a read request of an unsupported size are placed between reads. The next byte returned shows that neither moved the pointer, and that the unsupported read left its request word in place.

A behavioural model of all six registers is compared with the read port on every clock.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;

  // register map (byte offsets, low byte of the address)
  localparam int CTRL_OFS      = 'h10;
  localparam int DATA_BASE_OFS = 'h14;
  localparam int REG_STRIDE    = 4;

  // control word fields
  localparam int SEND_BIT  = 31;
  localparam int DONE_BIT  = 30;
  localparam int SIZE_LSB  = 20;
  localparam int SIZE_W    = 5;

  // request word fields (data register 1)
  localparam int CMD_LSB   = 28;
  localparam int CMD_W     = 4;
  localparam int ADDR_LSB  = 8;
  localparam int ADDR_W    = 16;
  localparam int CMD_RD    = 0;
  localparam int CMD_MOT   = 2;

  // reply word fields
  localparam int REPLY_BYTE_LSB = 16;
  localparam logic [7:0] REPLY_ACK  = 8'h00;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;

  localparam logic [SIZE_W-1:0] SIZE_ADDR_ONLY = 5'd3;
  localparam logic [SIZE_W-1:0] SIZE_ONE_BYTE  = 5'd4;

  typedef enum logic [3:0] {
    REQ_CLEAR,     // control write without send
    REQ_STOP,      // address-only, transaction ends
    REQ_RESET,     // address-only, address zero
    REQ_SELECT,    // address-only, EDID target
    REQ_ADDR_MISC, // address-only, other address
    REQ_WRITE,     // write command, data ignored
    REQ_READ,      // single byte read
    REQ_BAD_READ   // read command of unsupported size
  } req_kind_e;

endpackage

// File: rtl/aux_reg_decode.sv
module aux_reg_decode
  import aux_edid_pkg::*;
#(
  parameter int N_DATA = 5
) (
  input  logic [7:0]        addr,
  output logic              ctrl_hit,
  output logic [N_DATA-1:0] data_hit
);

  assign ctrl_hit = (addr == 8'(CTRL_OFS));

  for (genvar g = 0; g < N_DATA; g++) begin : g_hit
    assign data_hit[g] = (addr == 8'(DATA_BASE_OFS + g * REG_STRIDE));
  end

endmodule

// File: rtl/aux_req_classify.sv
module aux_req_classify
  import aux_edid_pkg::*;
#(
  parameter logic [15:0] TARGET_ADDR = 16'h0050
) (
  input  logic              send,
  input  logic [SIZE_W-1:0] msg_size,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] i2c_addr,
  output req_kind_e         kind,
  output logic [SIZE_W-1:0] reply_size
);

  assign reply_size = cmd[CMD_RD] ? 5'd2 : 5'd1;

  always_comb begin
    if (!send) begin
      kind = REQ_CLEAR;
    end else if (msg_size == SIZE_ADDR_ONLY) begin
      if (!cmd[CMD_MOT])               kind = REQ_STOP;
      else if (i2c_addr == '0)         kind = REQ_RESET;
      else if (i2c_addr == TARGET_ADDR) kind = REQ_SELECT;
      else                             kind = REQ_ADDR_MISC;
    end else if (!cmd[CMD_RD]) begin
      kind = REQ_WRITE;
    end else if (msg_size == SIZE_ONE_BYTE) begin
      kind = REQ_READ;
    end else begin
      kind = REQ_BAD_READ;
    end
  end

endmodule

// File: rtl/aux_i2c_session.sv
module aux_i2c_session
  import aux_edid_pkg::*;
#(
  parameter int EDID_DEPTH = 128,
  localparam int PTR_W     = $clog2(EDID_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  req_kind_e        kind,
  input  logic             mon_present,
  output logic             sel_o,
  output logic             avail_o,
  output logic [PTR_W-1:0] ptr_o
);

  logic             sel_q, avail_q;
  logic [PTR_W-1:0] ptr_q;
  logic             at_end;

  assign at_end = (ptr_q == PTR_W'(EDID_DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      avail_q <= 1'b0;
      ptr_q   <= '0;
    end else if (act) begin
      case (kind)
        REQ_STOP, REQ_RESET: begin
          sel_q   <= 1'b0;
          avail_q <= 1'b0;
          ptr_q   <= '0;
        end
        REQ_SELECT: begin
          sel_q   <= 1'b1;
          avail_q <= mon_present;
        end
        REQ_READ: begin
          if (sel_q && avail_q && !at_end) ptr_q <= ptr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign sel_o   = sel_q;
  assign avail_o = avail_q;
  assign ptr_o   = ptr_q;

  // pointer only steps by one or returns to zero
  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |-> (ptr_q == $past(ptr_q) + 1'b1 || ptr_q == '0));

  // a closing request empties the session
  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && kind == REQ_STOP) |=> (!sel_q && !avail_q && ptr_q == '0));

  // the pointer never passes the end of the store
  assert_ptr_cap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(at_end) && $past(kind) == REQ_READ) |-> (ptr_q == PTR_W'(EDID_DEPTH) || ptr_q == '0));

endmodule

// File: rtl/aux_edid_store.sv
module aux_edid_store #(
  parameter int EDID_DEPTH = 128,
  localparam int IDX_W     = $clog2(EDID_DEPTH),
  localparam int PTR_W     = $clog2(EDID_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_byte,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [7:0]       rd_byte
);

  logic [7:0] mem_q [EDID_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < EDID_DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (ld_en) begin
      mem_q[ld_idx] <= ld_byte;
    end
  end

  always_comb begin
    if (rd_ptr < PTR_W'(EDID_DEPTH)) rd_byte = mem_q[rd_ptr[IDX_W-1:0]];
    else                             rd_byte = 8'h00;
  end

endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder
  import aux_edid_pkg::*;
#(
  parameter int          N_DATA      = 5,
  parameter int          EDID_DEPTH  = 128,
  parameter logic [15:0] TARGET_ADDR = 16'h0050,
  localparam int         IDX_W       = $clog2(EDID_DEPTH),
  localparam int         PTR_W       = $clog2(EDID_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [7:0]       rd_addr,
  output logic [31:0]      rd_data,
  input  logic             edid_ld_en,
  input  logic [IDX_W-1:0] edid_ld_idx,
  input  logic [7:0]       edid_ld_byte,
  input  logic             dp_mon_present
);

  logic [31:0]              ctrl_q;
  logic [N_DATA-1:0][31:0]  data_q;
  logic                     rdy_q;

  logic                     w_ctrl_hit, r_ctrl_hit;
  logic [N_DATA-1:0]        w_data_hit, r_data_hit;
  req_kind_e                kind;
  logic [SIZE_W-1:0]        reply_size;
  logic                     sess_sel, sess_avail;
  logic [PTR_W-1:0]         sess_ptr;
  logic [7:0]               store_byte, reply_byte;
  logic                     take, ctrl_take;
  logic [31:0]              ctrl_next, reply_word;

  assign wr_ready  = rdy_q;
  assign take      = wr_valid && rdy_q;
  assign ctrl_take = take && w_ctrl_hit;

  aux_reg_decode #(.N_DATA(N_DATA)) u_wdec (
    .addr(wr_addr), .ctrl_hit(w_ctrl_hit), .data_hit(w_data_hit));

  aux_reg_decode #(.N_DATA(N_DATA)) u_rdec (
    .addr(rd_addr), .ctrl_hit(r_ctrl_hit), .data_hit(r_data_hit));

  aux_req_classify #(.TARGET_ADDR(TARGET_ADDR)) u_cls (
    .send       (wr_data[SEND_BIT]),
    .msg_size   (wr_data[SIZE_LSB +: SIZE_W]),
    .cmd        (data_q[0][CMD_LSB +: CMD_W]),
    .i2c_addr   (data_q[0][ADDR_LSB +: ADDR_W]),
    .kind       (kind),
    .reply_size (reply_size));

  aux_i2c_session #(.EDID_DEPTH(EDID_DEPTH)) u_sess (
    .clk(clk), .rst_n(rst_n), .act(ctrl_take), .kind(kind),
    .mon_present(dp_mon_present),
    .sel_o(sess_sel), .avail_o(sess_avail), .ptr_o(sess_ptr));

  aux_edid_store #(.EDID_DEPTH(EDID_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .ld_en(edid_ld_en), .ld_idx(edid_ld_idx),
    .ld_byte(edid_ld_byte), .rd_ptr(sess_ptr), .rd_byte(store_byte));

  assign reply_byte = (sess_sel && sess_avail) ? store_byte : FILL_BYTE;

  always_comb begin
    ctrl_next = '0;
    ctrl_next[DONE_BIT] = 1'b1;
    ctrl_next[SIZE_LSB +: SIZE_W] = reply_size;
    reply_word = '0;
    reply_word[31:24] = REPLY_ACK;
    if (kind == REQ_READ) reply_word[REPLY_BYTE_LSB +: 8] = reply_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (ctrl_take) begin
        if (kind == REQ_CLEAR) begin
          ctrl_q <= '0;
        end else begin
          ctrl_q <= ctrl_next;
          if (kind != REQ_BAD_READ) data_q[0] <= reply_word;
        end
      end else if (take) begin
        for (int g = 0; g < N_DATA; g++) begin
          if (w_data_hit[g]) data_q[g] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    rd_data = r_ctrl_hit ? ctrl_q : '0;
    for (int g = 0; g < N_DATA; g++) begin
      if (r_data_hit[g]) rd_data = rd_data | data_q[g];
    end
  end

  for (genvar g = 0; g < N_DATA; g++) begin : g_chk
    assert_data_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (take && w_data_hit[g]) |=> (data_q[g] == $past(wr_data)));
  end

  assert_clear_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_take && !wr_data[SEND_BIT]) |=> (ctrl_q == '0));

  assert_done_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_take && wr_data[SEND_BIT]) |=> (ctrl_q[DONE_BIT] && !ctrl_q[SEND_BIT]));

  assert_fill_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_take && kind == REQ_READ && !(sess_sel && sess_avail))
      |=> (data_q[0] == 32'h00FF_0000));

  assert_bad_read_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_take && kind == REQ_BAD_READ) |=> $stable(data_q[0]));

endmodule

// File: tb/tb_aux_edid_responder.sv
`timescale 1ns/100ps
module tb_aux_edid_responder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_addr = 8'h00;
  logic [31:0] wr_data = 32'h0;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic        edid_ld_en = 1'b0;
  logic [6:0]  edid_ld_idx = 7'h0;
  logic [7:0]  edid_ld_byte = 8'h0;
  logic        dp_mon_present = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  aux_edid_responder dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .edid_ld_en(edid_ld_en), .edid_ld_idx(edid_ld_idx), .edid_ld_byte(edid_ld_byte),
    .dp_mon_present(dp_mon_present));

  // ---------------- behavioural reference model ----------------
  logic [31:0] mctrl;
  logic [31:0] mdata [5];
  logic [7:0]  medid [128];
  bit          msel, mavail;
  int          mptr;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mctrl = 0;
      for (int i = 0; i < 5; i++) mdata[i] = 0;
      for (int i = 0; i < 128; i++) medid[i] = 0;
      msel = 0; mavail = 0; mptr = 0;
    end else begin
      if (edid_ld_en) medid[edid_ld_idx] = edid_ld_byte;
      if (wr_valid) begin
        if (wr_addr == 8'h10) begin
          logic [3:0] cmd; logic [15:0] a; int sz; logic [7:0] b;
          cmd = mdata[0][31:28]; a = mdata[0][23:8]; sz = int'(wr_data[24:20]);
          if (!wr_data[31]) mctrl = 0;
          else begin
            mctrl = 32'h4000_0000 | ((cmd[0] ? 32'd2 : 32'd1) << 20);
            if (sz == 3) begin
              if (!cmd[2] || a == 16'h0) begin msel = 0; mavail = 0; mptr = 0; end
              else if (a == 16'h0050) begin msel = 1; mavail = dp_mon_present; end
              mdata[0] = 0;
            end else if (!cmd[0]) mdata[0] = 0;
            else if (sz == 4) begin
              if (msel && mavail) begin
                b = (mptr < 128) ? medid[mptr] : 8'h00;
                if (mptr < 128) mptr++;
              end else b = 8'hFF;
              mdata[0] = {8'h00, b, 16'h0000};
            end
          end
        end else if (wr_addr >= 8'h14 && wr_addr <= 8'h24 && wr_addr[1:0] == 2'b00)
          mdata[(int'(wr_addr) - 'h14) / 4] = wr_data;
      end
    end
  end

  // per-clock comparison of every register through the read port
  logic [31:0] seen [7];

  function automatic logic [7:0] ofs(int k);
    if (k == 0) return 8'h10;
    if (k == 6) return 8'h28;
    return 8'(8'h14 + 4 * (k - 1));
  endfunction

  always @(negedge clk) begin
    for (int k = 0; k < 7; k++) begin
      logic [31:0] e;
      rd_addr = ofs(k);
      #0.2;
      seen[k] = rd_data;
      e = (k == 0) ? mctrl : (k == 6) ? 32'h0 : mdata[k-1];
      if (rst_n) begin
        checks++;
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s model reg %0d actual %h expected %h",
                   (k == 0) ? "R3" : "R1", k, rd_data, e);
        end
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    #1.6;
  endtask

  task automatic req(logic [31:0] d1, logic [31:0] c);
    wr(8'h14, d1);
    wr(8'h10, c);
  endtask

  localparam logic [31:0] RD_SEL  = 32'h5000_5000;  // read, mot, addr 0x50
  localparam logic [31:0] SEND3   = 32'h8030_0000;
  localparam logic [31:0] SEND4   = 32'h8040_0000;
  localparam logic [31:0] DONE_R  = 32'h4020_0000;
  localparam logic [31:0] DONE_W  = 32'h4010_0000;

  task automatic open_session(bit mon);
    dp_mon_present = mon;
    req(RD_SEL, SEND3);
  endtask

  task automatic rd_byte(string tag, logic [7:0] exp);
    req(RD_SEL, SEND4);
    chk(tag, seen[1], {8'h00, exp, 16'h0000});
    chk(tag, seen[0], DONE_R);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1.6;
    // R13 reset state
    for (int k = 0; k < 7; k++) chk("R13 reset", seen[k], 32'h0);
    chk("R13 ready", {31'h0, wr_ready}, 32'h1);

    // R14 load the store
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      edid_ld_en = 1'b1; edid_ld_idx = 7'(i); edid_ld_byte = pat(i);
    end
    @(negedge clk); edid_ld_en = 1'b0;

    // R1 data registers and an unmapped offset
    for (int k = 0; k < 5; k++) wr(ofs(k + 1), 32'hA5A5_0000 + 32'(k));
    for (int k = 0; k < 5; k++) chk("R1 store", seen[k+1], 32'hA5A5_0000 + 32'(k));
    wr(8'h28, 32'hDEAD_BEEF);
    chk("R1 unmapped", seen[6], 32'h0);
    chk("R1 unmapped no side effect", seen[2], 32'hA5A5_0001);

    // R9 read before any session
    rd_byte("R9 no session", 8'hFF);

    // R5 / R8 select and read
    open_session(1'b1);
    chk("R5 select reply", seen[1], 32'h0);
    chk("R3 size for read cmd", seen[0], DONE_R);
    rd_byte("R8 byte0", pat(0));
    rd_byte("R8 byte1", pat(1));
    rd_byte("R8 byte2", pat(2));

    // R2 clear without send
    wr(8'h10, 32'h0040_0000);
    chk("R2 ctrl cleared", seen[0], 32'h0);
    chk("R2 data kept", seen[1], {8'h00, pat(2), 16'h0});
    rd_byte("R2 session kept", pat(3));

    // R10 write request ignored apart from ACK
    req(32'h4000_5000, 32'h8050_0000);
    chk("R10 ack only", seen[1], 32'h0);
    chk("R3 size for write cmd", seen[0], DONE_W);
    rd_byte("R10 pointer kept", pat(4));

    // R11 read of unsupported size
    req(RD_SEL, 32'h8060_0000);
    chk("R11 data untouched", seen[1], RD_SEL);
    chk("R11 done", seen[0], DONE_R);
    rd_byte("R11 pointer kept", pat(5));

    // R4 stop then reopen restarts at 0
    req(32'h1000_5000, SEND3);
    chk("R4 stop reply", seen[1], 32'h0);
    rd_byte("R4 after stop", 8'hFF);
    open_session(1'b1);
    rd_byte("R4 restart", pat(0));

    // R6 address zero reset
    req(32'h5000_0000, SEND3);
    rd_byte("R6 after reset", 8'hFF);

    // R7 no monitor
    open_session(1'b0);
    rd_byte("R7 no monitor", 8'hFF);

    // R12 run off the end
    open_session(1'b1);
    for (int i = 0; i < 128; i++) begin
      req(RD_SEL, SEND4);
      if (i == 127) chk("R12 last entry", seen[1], {8'h00, pat(127), 16'h0});
    end
    rd_byte("R12 past end", 8'h00);
    rd_byte("R12 saturated", 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule